// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked on-chip bus and an external 32K x 8 asynchronous static RAM. A requester presents a single-word read or write with a 15-bit word address and, for writes, an 8-bit data byte. The sequencer then drives the three active-low memory strobes (select, read-drive and write), the address, and the shared data bus. When the access is finished it returns one done pulse, together with the read byte for a read.

The memory has no clock, so each phase of an access must last a minimum number of nanoseconds. The block receives the clock period and each timing minimum as parameters. From these it derives a whole number of clock cycles for every phase. A write pulse holds the strobe low long enough to cover the pulse width, the select-to-end and data-setup minima, and is then padded up to the full write cycle time. A read holds select and read-drive low for the slowest of the access times. The byte is sampled in the last cycle of that window. The block then waits long enough for the memory to release the bus before it accepts the next request.

The data bus is split into an outgoing byte, an incoming byte and a drive enable, so a pad ring can build the tristate. A request is taken only while the ready output is high. Ready is high only when no access is under way.

Top module: `async_sram_ctrl`

## Requirements
- R1: After a synchronous active-low reset, ready is 1, all three memory strobes are 1, the drive enable is 0 and done is 0.
- R2: Each timing window lasts ceil(minimum_ns / CLK_NS) cycles, with a floor of one cycle. With the defaults (20 ns clock) the read window is 4 cycles, the write-strobe window is 3 cycles, write recovery is 1 cycle and bus turnaround is 2 cycles.
- R3: A read holds select and read-drive low and the write strobe high for exactly the read window. The address stays at the requested value throughout. The incoming byte is sampled at the end of the last cycle of the window.
- R4: A write holds select and the write strobe low for exactly the write-strobe window while read-drive stays high. The bus is driven with the request byte only during cycles in which the write strobe is low. The drive is released in the same cycle in which the write strobe rises.
- R5: After the write strobe rises, ready stays low for the recovery cycles, so that the strobe window plus recovery covers the write cycle time.
- R6: After a read, ready stays low for the turnaround cycles. A later write strobe therefore falls at least that many cycles after read-drive rises.
- R7: A request is accepted only on a clock edge where request-valid and ready are both 1. Ready is 0 while an access is in progress, and a request presented during that time has no effect on the memory or on the access in progress.
- R8: Done is high for exactly one cycle per access, in the cycle after the strobes rise. For a read, the sampled byte is on the read-data output during that cycle.
- R9: The write strobe and the read-drive strobe are never low in the same cycle. Select is high whenever ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte read, valid with done |
| mem_sel_n | output | 1 | Memory select, active low |
| mem_rd_n | output | 1 | Memory output drive, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_out | output | 8 | Byte driven toward memory |
| mem_dq_in | input | 8 | Byte received from memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |

## Verification
The bench builds the block with its default timing: a 20 ns clock against 70/35 ns access, 50/60/30 ns write and 25 ns release minima. These values give four different window lengths (4, 3, 1 and 2 cycles), so an off-by-one in any single window or a swapped window shows up in the measured strobe widths. The one-cycle recovery is non-zero, so the path through recovery is exercised. The memory model returns valid data only once the read has lasted the full access time. As a result, sampling one cycle early returns a marker byte instead of the stored byte.

// File: rtl/sram_ctl_pkg.sv
// Shared types and cycle-count arithmetic for the static RAM sequencer.
// Assumes all timing values are positive integers in nanoseconds.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WRITE = 3'd2,
        ST_WREC  = 3'd3,
        ST_TURN  = 3'd4
    } seq_state_t;

    // Rounded-up quotient of a time by the clock period, never below one.
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
// Access sequencer: holds the phase state and a down-counter for the
// current window, raises ready only when idle and pulses done once per
// access. Assumes every window length parameter except WREC_CYC is >= 1.
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC   = 4,
    parameter int WL_CYC   = 3,
    parameter int WREC_CYC = 1,
    parameter int TA_CYC   = 2,
    parameter int CNT_W    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    output logic       req_ready,
    output logic       accept,
    output logic       rd_last,
    output logic       rsp_done,
    output seq_state_t state_nx
);

    localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WL_LD   = CNT_W'(WL_CYC - 1);
    localparam logic [CNT_W-1:0] WREC_LD = CNT_W'((WREC_CYC > 0) ? WREC_CYC - 1 : 0);
    localparam logic [CNT_W-1:0] TA_LD   = CNT_W'(TA_CYC - 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             win_end;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign win_end   = (cnt_q == '0);
    assign rd_last   = (state_q == ST_READ) && win_end;

    // Next phase and window counter.
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_nx = req_write ? ST_WRITE : ST_READ;
                    cnt_nx   = req_write ? WL_LD : RD_LD;
                end
            end
            ST_READ: begin
                if (win_end) begin
                    state_nx = ST_TURN;
                    cnt_nx   = TA_LD;
                end else begin
                    cnt_nx = cnt_q - 1'b1;
                end
            end
            ST_WRITE: begin
                if (win_end) begin
                    state_nx = (WREC_CYC > 0) ? ST_WREC : ST_IDLE;
                    cnt_nx   = WREC_LD;
                end else begin
                    cnt_nx = cnt_q - 1'b1;
                end
            end
            ST_WREC, ST_TURN: begin
                if (win_end) state_nx = ST_IDLE;
                else         cnt_nx   = cnt_q - 1'b1;
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // Phase, counter and done-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            rsp_done <= 1'b0;
        end else begin
            state_q  <= state_nx;
            cnt_q    <= cnt_nx;
            rsp_done <= ((state_q == ST_READ) || (state_q == ST_WRITE)) && win_end;
        end
    end

    // R8: done never lasts two cycles.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R7: a busy sequencer never reports ready in the cycle after an accept.
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

endmodule

// File: rtl/sram_pin_drive.sv
// Memory-side pin registers: strobes, address, outgoing byte and drive
// enable are all registered from the next phase, so the pins never glitch.
// Assumes address and write byte are captured only on an accepted request.
module sram_pin_drive
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state_nx,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              mem_sel_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);

    // Strobe and drive-enable registers decoded from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_sel_n <= 1'b1;
            mem_rd_n  <= 1'b1;
            mem_wr_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_sel_n <= !((state_nx == ST_READ) || (state_nx == ST_WRITE));
            mem_rd_n  <= (state_nx != ST_READ);
            mem_wr_n  <= (state_nx != ST_WRITE);
            mem_dq_oe <= (state_nx == ST_WRITE);
        end
    end

    // Address and write-byte capture on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // R9: write strobe and read-drive strobe never overlap.
    a_r9_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_wr_n && !mem_rd_n));

    // R4: the bus is driven only inside a selected write strobe.
    a_r4_drive_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_wr_n && !mem_sel_n));

    // R4: drive is gone in the cycle the write strobe rises.
    a_r4_release_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> !mem_dq_oe);

    // R3: address holds while select stays low.
    a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

endmodule

// File: rtl/sram_rd_capture.sv
// Read-data register: samples the incoming byte at the end of the last
// cycle of the read window and holds it for the done pulse.
// Assumes rd_last is high for exactly one cycle per read.
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_last,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [DATA_W-1:0] rsp_rdata
);

    // Capture register for the read byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       rsp_rdata <= '0;
        else if (rd_last) rsp_rdata <= mem_dq_in;
    end

endmodule

// File: rtl/async_sram_ctrl.sv
// Top of the static RAM sequencer: converts timing minima in nanoseconds
// into cycle counts and joins the phase machine, pin registers and read
// capture. Assumes one outstanding request at a time.
module async_sram_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS  = 20,
    parameter int T_RC_NS = 70,
    parameter int T_AA_NS = 70,
    parameter int T_OE_NS = 35,
    parameter int T_WC_NS = 70,
    parameter int T_WP_NS = 50,
    parameter int T_CW_NS = 60,
    parameter int T_DW_NS = 30,
    parameter int T_HZ_NS = 25,
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_sel_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int RD_CYC   = ns_to_cyc(imax(T_RC_NS, imax(T_AA_NS, T_OE_NS)), CLK_NS);
    localparam int WL_CYC   = ns_to_cyc(imax(T_WP_NS, imax(T_CW_NS, T_DW_NS)), CLK_NS);
    localparam int WC_CYC   = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int WREC_CYC = (WC_CYC > WL_CYC) ? (WC_CYC - WL_CYC) : 0;
    localparam int TA_CYC   = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int MAX_CYC  = imax(imax(RD_CYC, WL_CYC), imax(WREC_CYC, TA_CYC));
    localparam int CNT_W    = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
    localparam int RUN_W    = CNT_W + 2;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    seq_state_t state_nx;
    logic       accept;
    logic       rd_last;

    sram_seq_fsm #(
        .RD_CYC  (RD_CYC),
        .WL_CYC  (WL_CYC),
        .WREC_CYC(WREC_CYC),
        .TA_CYC  (TA_CYC),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_ready(req_ready),
        .accept   (accept),
        .rd_last  (rd_last),
        .rsp_done (rsp_done),
        .state_nx (state_nx)
    );

    sram_pin_drive #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_nx  (state_nx),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_sel_n (mem_sel_n),
        .mem_rd_n  (mem_rd_n),
        .mem_wr_n  (mem_wr_n),
        .mem_addr  (mem_addr),
        .mem_dq_out(mem_dq_out),
        .mem_dq_oe (mem_dq_oe)
    );

    sram_rd_capture #(
        .DATA_W(DATA_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_last  (rd_last),
        .mem_dq_in(mem_dq_in),
        .rsp_rdata(rsp_rdata)
    );

    // Checker counters: strobe-low run lengths and cycles since read-drive rose.
    logic [RUN_W-1:0] wr_run, rd_run, rd_gap;

    // Saturating run-length counters for the window checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_run <= '0;
            rd_run <= '0;
            rd_gap <= RUN_MAX;
        end else begin
            wr_run <= mem_wr_n ? '0 : ((wr_run == RUN_MAX) ? wr_run : wr_run + 1'b1);
            rd_run <= mem_rd_n ? '0 : ((rd_run == RUN_MAX) ? rd_run : rd_run + 1'b1);
            rd_gap <= !mem_rd_n ? '0 : ((rd_gap == RUN_MAX) ? rd_gap : rd_gap + 1'b1);
        end
    end

    // R2/R4: write strobe low for exactly the write-strobe window.
    a_r4_wr_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (wr_run == RUN_W'(WL_CYC)));

    // R2/R3: read-drive low for exactly the read window.
    a_r3_rd_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_n) |-> (rd_run == RUN_W'(RD_CYC)));

    // R6: a write strobe falls only after the bus-release turnaround.
    a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> (rd_gap >= RUN_W'(TA_CYC)));

    // R9: select is high whenever the sequencer is ready.
    a_r9_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_sel_n);

endmodule

// File: tb/tb_async_sram_ctrl.sv
// Bench for the static RAM sequencer: a behavioural memory with a modelled
// access delay, directed corner cases and seeded random read/write traffic.
module tb_async_sram_ctrl;

    localparam int CLK_NS = 20;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_RD   = cyc(70);
    localparam int E_WL   = cyc(60);
    localparam int E_WC   = cyc(70);
    localparam int E_WREC = (E_WC > E_WL) ? E_WC - E_WL : 0;
    localparam int E_TA   = cyc(25);
    localparam int E_ACC  = cyc(70);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic        mem_sel_n, mem_rd_n, mem_wr_n, mem_dq_oe;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int nchecks = 0;
    int nerrors = 0;

    logic [7:0] model_mem [int unsigned];
    logic [7:0] exp_mem   [int unsigned];
    int         acc_run = 0;

    always #(CLK_NS / 2) clk = ~clk;

    async_sram_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_sel_n(mem_sel_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    // Memory model: stores during selected write strobe, returns data only
    // after the full access time, otherwise a marker byte.
    always @(negedge clk) begin
        if (!mem_sel_n && !mem_wr_n && mem_dq_oe)
            model_mem[int'(mem_addr)] = mem_dq_out;
        if (!mem_sel_n && !mem_rd_n && mem_wr_n) acc_run = acc_run + 1;
        else                                     acc_run = 0;
        if (acc_run >= E_ACC)
            mem_dq_in = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in = 8'hEE;
    end

    task automatic chk(input string req, input int act, input int exp);
        nchecks++;
        if (act !== exp) begin
            nerrors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [14:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00;
    endfunction

    // One access; optional noise request presented while busy (R7).
    task automatic run_op(input bit wr, input logic [14:0] a, input logic [7:0] d,
                          input bit noise);
        int sel_lo = 0, rd_lo = 0, wr_lo = 0, drv = 0, busy = 0, ndone = 0;
        int bad_addr = 0, bad_drv = 0, guard = 0;
        logic [7:0] got = 8'h00;
        while (!req_ready && guard < 64) begin @(negedge clk); guard++; end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        guard = 0;
        req_valid = noise;
        if (noise) begin req_write = 1'b1; req_addr = a ^ 15'h1; req_wdata = ~d; end
        forever begin
            if (rsp_done) begin ndone++; got = rsp_rdata; end
            if (req_ready || guard >= 64) break;
            busy++;
            if (!mem_sel_n) begin sel_lo++; if (mem_addr !== a) bad_addr++; end
            if (!mem_rd_n) rd_lo++;
            if (!mem_wr_n) wr_lo++;
            if (mem_dq_oe) begin drv++; if (mem_dq_out !== d || mem_wr_n) bad_drv++; end
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b0;
        if (wr) begin
            chk("R4 select-low cycles", sel_lo, E_WL);
            chk("R2 write-strobe cycles", wr_lo, E_WL);
            chk("R4 drive cycles", drv, E_WL);
            chk("R4 drive byte/strobe", bad_drv, 0);
            chk("R9 read-drive during write", rd_lo, 0);
            chk("R5 write busy cycles", busy, E_WL + E_WREC);
            exp_mem[int'(a)] = d;
        end else begin
            chk("R3 select-low cycles", sel_lo, E_RD);
            chk("R2 read-drive cycles", rd_lo, E_RD);
            chk("R9 write strobe during read", wr_lo, 0);
            chk("R3 no drive during read", drv, 0);
            chk("R6 read busy cycles", busy, E_RD + E_TA);
            chk("R3 read data", got, exp_read(a));
        end
        chk("R3 address held", bad_addr, 0);
        chk("R8 done pulses", ndone, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerrors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports.
        chk("R1 ready", req_ready, 1);
        chk("R1 select", mem_sel_n, 1);
        chk("R1 read-drive", mem_rd_n, 1);
        chk("R1 write strobe", mem_wr_n, 1);
        chk("R1 drive enable", mem_dq_oe, 0);
        chk("R1 done", rsp_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: valid low means nothing starts.
        chk("R7 idle without valid", mem_sel_n, 1);

        // Directed corners: lowest and highest address, unwritten read.
        run_op(1'b1, 15'h0000, 8'hA5, 1'b0);
        run_op(1'b1, 15'h7FFF, 8'h3C, 1'b0);
        run_op(1'b0, 15'h0000, 8'h00, 1'b0);
        run_op(1'b0, 15'h7FFF, 8'h00, 1'b0);
        run_op(1'b0, 15'h1234, 8'h00, 1'b0);
        // R7: request held during a busy write is ignored.
        run_op(1'b1, 15'h0100, 8'h5A, 1'b1);
        run_op(1'b0, 15'h0101, 8'h00, 1'b0);
        run_op(1'b0, 15'h0100, 8'h00, 1'b0);
        // R6: write immediately after a read.
        run_op(1'b0, 15'h7FFF, 8'h00, 1'b0);
        run_op(1'b1, 15'h7FFF, 8'hC3, 1'b0);
        run_op(1'b0, 15'h7FFF, 8'h00, 1'b0);

        // Seeded random traffic over a clustered address set.
        for (int i = 0; i < 300; i++) begin
            logic [14:0] a;
            a = 15'($urandom) & 15'h603F;
            run_op(1'($urandom), a, 8'($urandom), (($urandom % 8) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end

endmodule